// File: doc/BRIEF.md
# Activity-Reloaded Watchdog Timer

This block is a watchdog counter placed behind a small byte-wide register port. Software programs a count and a unit (seconds or minutes), then chooses which kinds of system activity keep the watchdog alive. Four event inputs feed the reload path: a game-port read strobe, a consumer-IR data write strobe, a keyboard interrupt pulse and a mouse interrupt pulse. Each of these reloads the counter only when its enable bit is set. A reload takes effect a fixed number of clock cycles after the event, which models the short settling delay of the real hardware.

A one-second prescaler tick comes in from outside. In minute mode an internal divide-by-60 turns these ticks into minute ticks, and every reload or count write restarts that divider. When the count steps from 1 to 0, or when software forces a timeout, a sticky status flag is set. Depending on the configuration, the block also produces a fixed-length keyboard-reset pulse, a power-good-drop pulse and a one-cycle timeout event. Software stops the watchdog by writing a zero count. It clears the flag by writing zero to the control register.

Register select (`reg_sel`): 0 = control, 1 = configuration, 2 = count low byte, 3 = count high byte. Reading a count byte returns the live counter. With `CNT_BYTES` = 1 the high byte reads as zero and writes to it are dropped.

Top module: `activity_wdt`

## Requirements
- R1: After reset the control register reads 0x00, the configuration register reads 0x80, both count bytes read 0x00, and all three outputs are low.
- R2: Writing a count byte so that the new programmed count is nonzero loads the live counter at once, and the live counter reads back through select 2 (low byte) and select 3 (high byte). A programmed count of zero stops the watchdog: the counter does not move, no timeout occurs, and reload events are ignored.
- R3: With configuration bit 7 = 1 (seconds), each `sec_tick` lowers a running count by one. The step from 1 to 0 sets the status flag, which is control bit 0.
- R4: With configuration bit 7 = 0 (minutes), the count drops once per 60 `sec_tick` pulses.
- R5: Each event has its own reload enable: control bit 7 for consumer-IR writes, bit 6 for mouse, bit 5 for keyboard and bit 4 for game-port reads. An enabled event loads the programmed count into a running counter exactly `RELOAD_DLY` clock cycles after the event is sampled. A disabled event has no effect.
- R6: A reload, and likewise a count write, restarts the minute divider, so the next minute step needs a full 60 ticks.
- R7: Writing the control register with bit 1 set causes an immediate timeout. Bit 1 always reads back as 0.
- R8: The status flag stays set through any nonzero control write. Only a control write of 0x00 clears it.
- R9: On a timeout, `kbd_rst_o` goes high for exactly `PULSE_LEN` cycles if configuration bit 6 is set, and `pgood_drop_o` does the same if configuration bit 4 is set. The status flag is set either way.
- R10: On a timeout, `tmo_evt_o` goes high for exactly one cycle if configuration bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sec_tick | input | 1 | One-second prescaler tick, one cycle wide |
| gp_rd_evt | input | 1 | Game-port read strobe |
| cir_wr_evt | input | 1 | Consumer-IR data write strobe |
| kbd_irq_evt | input | 1 | Keyboard interrupt pulse |
| mse_irq_evt | input | 1 | Mouse interrupt pulse |
| kbd_rst_o | output | 1 | Keyboard-reset pulse on timeout |
| pgood_drop_o | output | 1 | Power-good-drop pulse on timeout |
| tmo_evt_o | output | 1 | One-cycle timeout event |

## Verification
Some behaviours are checked by assertions on every cycle. A stopped counter must stay at zero. A running counter must step down by exactly one on each unit tick. A reload must land the programmed count. A timeout must set the flag, and the flag must stay set until a zero control write. Every pulse trigger must raise its output on the next cycle.

Other behaviours only the bench scenarios can show. These are the exact reload latency measured from the event, the 60-tick minute period and its restart after a reload, the full length of the reset pulse, register read-back values, and the fact that disabled events and a stopped counter produce nothing at the outputs.

// File: rtl/awdt_pkg.sv
package awdt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_CNT_LO = 2'd2,
    SEL_CNT_HI = 2'd3
  } awdt_sel_e;

  localparam int CTL_CIR_EN  = 7;
  localparam int CTL_MSE_EN  = 6;
  localparam int CTL_KBD_EN  = 5;
  localparam int CTL_GP_EN   = 4;
  localparam int CTL_FORCE   = 1;
  localparam int CTL_STATUS  = 0;

  localparam int CFG_UNIT_SEC = 7;
  localparam int CFG_KRST_EN  = 6;
  localparam int CFG_EVT_EN   = 5;
  localparam int CFG_PGD_EN   = 4;

  localparam logic [7:0] CFG_RESET = 8'h80;
  localparam int NUM_EVT = 4;
endpackage

// File: rtl/awdt_regs.sv
module awdt_regs
  import awdt_pkg::*;
#(
  parameter int CNT_BYTES = 2,
  localparam int CNT_W = 8 * CNT_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [CNT_W-1:0] live_cnt,
  input  logic             timeout,
  output logic [NUM_EVT-1:0] evt_en,
  output logic [7:0]       cfg,
  output logic [CNT_W-1:0] prog,
  output logic [CNT_W-1:0] cnt_wval,
  output logic             cnt_wr,
  output logic             force_tmo,
  output logic             status
);
  logic [NUM_EVT-1:0] en_q, en_d;
  logic [7:0]         cfg_q, cfg_d;
  logic [CNT_W-1:0]   prog_q, prog_d;
  logic               stat_q, stat_d;
  logic               wr_ctrl;
  logic [7:0]         hi_rd;

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

  generate
    if (CNT_BYTES > 1) begin : g_hi
      assign hi_rd = live_cnt[CNT_W-1 -: 8];
    end else begin : g_no_hi
      assign hi_rd = 8'h00;
    end
  endgenerate

  always_comb begin
    en_d   = en_q;
    cfg_d  = cfg_q;
    prog_d = prog_q;
    cnt_wr = 1'b0;
    if (wr_ctrl) en_d = reg_wdata[CTL_CIR_EN:CTL_GP_EN];
    if (reg_wr && reg_sel == SEL_CFG) cfg_d = reg_wdata;
    if (reg_wr && reg_sel == SEL_CNT_LO) begin
      prog_d[7:0] = reg_wdata;
      cnt_wr      = 1'b1;
    end
    if (CNT_BYTES > 1 && reg_wr && reg_sel == SEL_CNT_HI) begin
      prog_d[CNT_W-1 -: 8] = reg_wdata;
      cnt_wr               = 1'b1;
    end
    if (timeout)                        stat_d = 1'b1;
    else if (wr_ctrl && reg_wdata == 8'h00) stat_d = 1'b0;
    else                                stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cfg_q  <= CFG_RESET;
      prog_q <= '0;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cfg_q  <= cfg_d;
      prog_q <= prog_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL:   reg_rdata = {en_q, 3'b000, stat_q};
      SEL_CFG:    reg_rdata = cfg_q;
      SEL_CNT_LO: reg_rdata = live_cnt[7:0];
      default:    reg_rdata = hi_rd;
    endcase
  end

  assign evt_en    = en_q;
  assign cfg       = cfg_q;
  assign prog      = prog_q;
  assign cnt_wval  = prog_d;
  assign force_tmo = wr_ctrl && reg_wdata[CTL_FORCE];
  assign status    = stat_q;

  // R3: a timeout always leaves the flag set
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> stat_q);
  // R8: flag only falls on a zero control write
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(wr_ctrl && reg_wdata == 8'h00)) |=> stat_q);
endmodule

// File: rtl/awdt_reload.sv
module awdt_reload
  import awdt_pkg::*;
#(
  parameter int RELOAD_DLY = 4,
  localparam int DLY_W = (RELOAD_DLY > 1) ? $clog2(RELOAD_DLY) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] evt_en,
  output logic               fire
);
  logic             pend_q, pend_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             hit;

  assign hit  = |(evt_in & evt_en);
  assign fire = pend_q && (dly_q == DLY_W'(RELOAD_DLY - 1));

  always_comb begin
    pend_d = pend_q;
    dly_d  = dly_q;
    if (!pend_q) begin
      if (hit) begin
        pend_d = 1'b1;
        dly_d  = '0;
      end
    end else if (fire) begin
      pend_d = 1'b0;
    end else begin
      dly_d = dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else begin
      pend_q <= pend_d;
      dly_q  <= dly_d;
    end
  end

  // R5: an idle reload path with no enabled event stays idle
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !hit) |=> !pend_q);
endmodule

// File: rtl/awdt_counter.sv
module awdt_counter #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 60,
  localparam int DIV_W  = $clog2(MIN_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             unit_sec,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic             reload,
  input  logic [CNT_W-1:0] prog,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             div_wrap, unit_tick, running, reload_eff;

  assign running    = (cnt_q != '0);
  assign reload_eff = reload && running;
  assign div_wrap   = (div_q == DIV_W'(MIN_DIV - 1));
  assign unit_tick  = sec_tick && (unit_sec || div_wrap);
  assign expire     = !cnt_wr && !reload_eff && unit_tick && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    if (cnt_wr || reload_eff)
      div_d = '0;
    else if (sec_tick)
      div_d = div_wrap ? '0 : div_q + 1'b1;
    if (cnt_wr)
      cnt_d = cnt_wval;
    else if (reload_eff)
      cnt_d = prog;
    else if (unit_tick && running)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign cnt = cnt_q;

  // R2: a stopped counter stays stopped without a count write
  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr) |=> (cnt_q == '0));
  // R3: one step per unit tick
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && unit_tick && !cnt_wr && !reload) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5: a reload on a running counter lands the programmed value
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && running && !cnt_wr) |=> (cnt_q == $past(prog)));
endmodule

// File: rtl/awdt_pulse.sv
module awdt_pulse #(
  parameter int PULSE_LEN = 16,
  localparam int PL_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  logic [PL_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (trig)                left_d = PL_W'(PULSE_LEN);
    else if (left_q != '0)   left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  // R9: a trigger raises the pulse on the next cycle
  assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);
endmodule

// File: rtl/activity_wdt.sv
module activity_wdt
  import awdt_pkg::*;
#(
  parameter int CNT_BYTES  = 2,
  parameter int RELOAD_DLY = 4,
  parameter int PULSE_LEN  = 16,
  parameter int MIN_DIV    = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sec_tick,
  input  logic       gp_rd_evt,
  input  logic       cir_wr_evt,
  input  logic       kbd_irq_evt,
  input  logic       mse_irq_evt,
  output logic       kbd_rst_o,
  output logic       pgood_drop_o,
  output logic       tmo_evt_o
);
  localparam int CNT_W = 8 * CNT_BYTES;

  logic               rs_meta, rs_n;
  logic [NUM_EVT-1:0] evt_en, evt_in;
  logic [7:0]         cfg;
  logic [CNT_W-1:0]   prog, cnt_wval, live;
  logic               cnt_wr, force_tmo, status, fire, expire, timeout;
  logic               evt_q, evt_d;
  logic               trig_krst, trig_pgd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign evt_in = {cir_wr_evt, mse_irq_evt, kbd_irq_evt, gp_rd_evt};

  awdt_regs #(.CNT_BYTES(CNT_BYTES)) u_regs (
    .clk(clk), .rst_n(rs_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .live_cnt(live),
    .timeout(timeout), .evt_en(evt_en), .cfg(cfg), .prog(prog),
    .cnt_wval(cnt_wval), .cnt_wr(cnt_wr), .force_tmo(force_tmo),
    .status(status)
  );

  awdt_reload #(.RELOAD_DLY(RELOAD_DLY)) u_reload (
    .clk(clk), .rst_n(rs_n), .evt_in(evt_in), .evt_en(evt_en), .fire(fire)
  );

  awdt_counter #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_cnt (
    .clk(clk), .rst_n(rs_n), .sec_tick(sec_tick), .unit_sec(cfg[CFG_UNIT_SEC]),
    .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .reload(fire), .prog(prog),
    .cnt(live), .expire(expire)
  );

  assign timeout   = expire || force_tmo;
  assign trig_krst = timeout && cfg[CFG_KRST_EN];
  assign trig_pgd  = timeout && cfg[CFG_PGD_EN];
  assign evt_d     = timeout && cfg[CFG_EVT_EN];

  awdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_krst (
    .clk(clk), .rst_n(rs_n), .trig(trig_krst), .pulse(kbd_rst_o)
  );
  awdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pgd (
    .clk(clk), .rst_n(rs_n), .trig(trig_pgd), .pulse(pgood_drop_o)
  );

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) evt_q <= 1'b0;
    else       evt_q <= evt_d;
  end
  assign tmo_evt_o = evt_q;

  // R10: the event output is a single-cycle pulse
  assert_evt_single_R10: assert property (@(posedge clk) disable iff (!rs_n)
    (tmo_evt_o && !evt_d) |=> !tmo_evt_o);
  // R7: a forcing control write always records a timeout
  assert_force_R7: assert property (@(posedge clk) disable iff (!rs_n)
    force_tmo |=> status);
endmodule

// File: tb/sim_activity_wdt.sv
module sim_activity_wdt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sec_tick = 1'b0;
  logic gp = 1'b0, cir = 1'b0, kbd = 1'b0, mse = 1'b0;
  logic kbd_rst_o, pgood_drop_o, tmo_evt_o;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  activity_wdt u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .gp_rd_evt(gp), .cir_wr_evt(cir), .kbd_irq_evt(kbd), .mse_irq_evt(mse),
    .kbd_rst_o(kbd_rst_o), .pgood_drop_o(pgood_drop_o), .tmo_evt_o(tmo_evt_o)
  );

  // {select, write data, expected read-back}
  localparam logic [17:0] VEC [5] = '{
    {2'd1, 8'h5A, 8'h5A},
    {2'd0, 8'hF0, 8'hF0},
    {2'd2, 8'h34, 8'h34},
    {2'd3, 8'h12, 8'h12},
    {2'd1, 8'h9F, 8'h9F}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic stop_all();
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int hi_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(2'd0, r); check("R1 ctrl reset", 16'(r), 16'h00);
    rd(2'd1, r); check("R1 cfg reset", 16'(r), 16'h80);
    rd(2'd2, r); check("R1 lo reset", 16'(r), 16'h00);
    rd(2'd3, r); check("R1 hi reset", 16'(r), 16'h00);
    check("R1 outputs low", 16'({kbd_rst_o, pgood_drop_o, tmo_evt_o}), 16'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], r);
      check("R2 vector readback", 16'(r), 16'(VEC[i][7:0]));
    end
    stop_all();

    // R3 R9: seconds countdown with keyboard reset
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'h03);
    rd(2'd2, r); check("R2 load", 16'(r), 16'h03);
    tick(2);
    rd(2'd2, r); check("R3 two steps", 16'(r), 16'h01);
    rd(2'd0, r); check("R3 no flag yet", 16'(r), 16'h00);
    tick(1);
    rd(2'd0, r); check("R3 flag on expiry", 16'(r), 16'h01);
    check("R10 event disabled", 16'(tmo_evt_o), 16'h0);
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (kbd_rst_o) hi_cnt++;
      check("R9 pgood disabled", 16'(pgood_drop_o), 16'h0);
      @(negedge clk);
    end
    check("R9 reset pulse length", 16'(hi_cnt), 16'd16);

    // R8 sticky flag
    wr(2'd0, 8'h10);
    rd(2'd0, r); check("R8 flag kept", 16'(r), 16'h11);
    wr(2'd0, 8'h00);
    rd(2'd0, r); check("R8 flag cleared", 16'(r), 16'h00);

    // R4 minute mode
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h02);
    tick(59);
    rd(2'd2, r); check("R4 59 ticks", 16'(r), 16'h02);
    tick(1);
    rd(2'd2, r); check("R4 60 ticks", 16'(r), 16'h01);
    stop_all();

    // R5 reload delay
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h05);
    tick(3);
    @(negedge clk); kbd = 1'b1;
    @(negedge clk); kbd = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd2, r); check("R5 disabled event ignored", 16'(r), 16'h02);
    @(negedge clk); gp = 1'b1;
    @(negedge clk); gp = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd2, r); check("R5 before delay", 16'(r), 16'h02);
    @(negedge clk);
    rd(2'd2, r); check("R5 after delay", 16'(r), 16'h05);
    stop_all();

    // R6 reload restarts minute divider
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h03);
    tick(30);
    @(negedge clk); kbd = 1'b1;
    @(negedge clk); kbd = 1'b0;
    repeat (6) @(negedge clk);
    tick(59);
    rd(2'd2, r); check("R6 divider restarted", 16'(r), 16'h03);
    tick(1);
    rd(2'd2, r); check("R6 minute step", 16'(r), 16'h02);
    stop_all();

    // R2 stop: zero count ignores ticks and events
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hF0);
    tick(3);
    @(negedge clk); gp = 1'b1; cir = 1'b1;
    @(negedge clk); gp = 1'b0; cir = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd2, r); check("R2 stopped count", 16'(r), 16'h00);
    rd(2'd0, r); check("R2 no timeout when stopped", 16'(r), 16'hF0);
    check("R2 outputs quiet", 16'({kbd_rst_o, pgood_drop_o, tmo_evt_o}), 16'h0);
    wr(2'd0, 8'h00);

    // R7 R9 R10 forced timeout
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'h02);
    check("R10 event pulse", 16'(tmo_evt_o), 16'h1);
    check("R9 pgood pulse", 16'(pgood_drop_o), 16'h1);
    check("R9 krst disabled", 16'(kbd_rst_o), 16'h0);
    rd(2'd0, r); check("R7 forced flag", 16'(r), 16'h01);
    @(negedge clk);
    check("R10 event one cycle", 16'(tmo_evt_o), 16'h0);
    wr(2'd0, 8'h00);

    // R2 16-bit count
    wr(2'd1, 8'h80);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd3, r); check("R2 high byte", 16'(r), 16'h01);
    tick(1);
    rd(2'd2, r); check("R3 borrow low", 16'(r), 16'hFF);
    rd(2'd3, r); check("R3 borrow high", 16'(r), 16'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule